// File: doc/BRIEF.md
# Eight-Function Carry-Skip ALU

This block is a purely combinational arithmetic logic unit for two equal-width operands, 16 bits by default. A 3-bit operation code selects one of eight functions: two arithmetic (add and subtract) and six bitwise (NOR, NAND, OR, AND, XOR, and complement of the first operand). The unit returns the selected result and a carry flag. There are no clocks and no registers. Outputs follow the inputs within the same cycle, so the block can sit inside an execute stage that the surrounding pipeline registers.

The arithmetic path is one adder that add and subtract share. It is a cascade of fixed-size carry-skip groups, four bits wide by default. Inside each group the carry ripples through per-bit slices. When every bit of a group propagates, the group passes its incoming carry straight to its outgoing carry. Subtraction runs through the same adder: the second operand is complemented and the carry into bit 0 is forced to one.

Every bit slice computes all eight candidate results for its bit position. A one-hot selector, decoded from the operation code, then picks one of them for each bit.

Top module: `aluCore`

## Requirements
- R1: With operation code 000 (add), `result` equals (`opA` + `opB`) modulo 2^WIDTH, and `carryOut` equals bit WIDTH of the full sum.
- R2: With operation code 001 (subtract), `result` equals (`opA` - `opB`) modulo 2^WIDTH, and `carryOut` equals the final carry of `opA` + ~`opB` + 1. This carry is 1 exactly when `opA` >= `opB` as unsigned values; it is 1 when `opA` equals `opB`.
- R3: With operation code 010, `result` is the bitwise NOR of `opA` and `opB`.
- R4: With operation code 011, `result` is the bitwise NAND of `opA` and `opB`.
- R5: With operation code 100, `result` is the bitwise OR of `opA` and `opB`.
- R6: With operation code 101, `result` is the bitwise AND of `opA` and `opB`.
- R7: With operation code 110, `result` is the bitwise XOR of `opA` and `opB`.
- R8: With operation code 111, `result` is the bitwise complement of `opA`, and `opB` has no effect on it.
- R9: For every operation code from 010 to 111, `carryOut` is 0, whatever the operand values.
- R10: A carry produced in the lowest group reaches `carryOut` through every group when all higher bits propagate. For example, 0xFFFF + 0x0001 gives `result` 0x0000 and `carryOut` 1.
- R11: The unit holds no state. After any input change, `result` and `carryOut` take their new values in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand (minuend for subtract, the operand complemented by code 111) |
| opB | input | WIDTH | Second operand (subtrahend for subtract) |
| opSel | input | 3 | Operation code: 000 add, 001 sub, 010 NOR, 011 NAND, 100 OR, 101 AND, 110 XOR, 111 complement A |
| result | output | WIDTH | Selected function result |
| carryOut | output | 1 | Adder carry for add and subtract, 0 for the logic operations |

## Verification
In subtraction, the inverted operand and the forced carry into bit 0 act together, and that carry can then either ripple inside a group or skip over it. A narrow instance (8 bits in 2-bit groups) is swept over every operand pair for all eight codes, so each mix of skip and ripple at each group boundary is reached in both add and subtract. The 16-bit instance then runs all-ones, 0x8000, equal-operand and random cases. Every vector is judged against sums and bitwise results that the bench computes with plain integer arithmetic.

// File: rtl/aluPkg.sv
`timescale 1ns/1ps
package aluPkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_NOR  = 3'b010,
    OP_NAND = 3'b011,
    OP_OR   = 3'b100,
    OP_AND  = 3'b101,
    OP_XOR  = 3'b110,
    OP_INV  = 3'b111
  } aluOpE;

  localparam int NUM_FUNCS = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                 invertB;   // complement second operand into adder
    logic                 carryIn;   // carry into bit 0
    logic                 carryEn;   // let the adder carry reach the port
    logic [NUM_FUNCS-1:0] funcSel;   // one-hot function pick
  } aluCtrlT;

endpackage

// File: rtl/aluControl.sv
`timescale 1ns/1ps
module aluControl
  import aluPkg::*;
(
  input  aluOpE   opCode,
  output aluCtrlT ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.funcSel = NUM_FUNCS'(1) << opCode;
    ctrl.invertB = (opCode == OP_SUB);
    ctrl.carryIn = (opCode == OP_SUB);
    ctrl.carryEn = (opCode == OP_ADD) || (opCode == OP_SUB);
  end

endmodule

// File: rtl/aluBitSlice.sv
`timescale 1ns/1ps
module aluBitSlice
  import aluPkg::*;
(
  input  logic                 aBit,
  input  logic                 bBit,
  input  logic                 invB,
  input  logic                 cin,
  output logic                 prop,
  output logic                 cout,
  output logic [NUM_FUNCS-1:0] funcs
);

  logic bEff;
  logic sumBit;

  always_comb begin
    bEff   = bBit ^ invB;
    prop   = aBit ^ bEff;
    sumBit = prop ^ cin;
    cout   = (aBit & bEff) | (prop & cin);

    funcs          = '0;
    funcs[OP_ADD]  = sumBit;
    funcs[OP_SUB]  = sumBit;
    funcs[OP_NOR]  = ~(aBit | bBit);
    funcs[OP_NAND] = ~(aBit & bBit);
    funcs[OP_OR]   = aBit | bBit;
    funcs[OP_AND]  = aBit & bBit;
    funcs[OP_XOR]  = aBit ^ bBit;
    funcs[OP_INV]  = ~aBit;
  end

endmodule

// File: rtl/aluSkipGroup.sv
`timescale 1ns/1ps
module aluSkipGroup
  import aluPkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0]                aIn,
  input  logic [GW-1:0]                bIn,
  input  logic                         invB,
  input  logic                         cin,
  output logic [GW-1:0][NUM_FUNCS-1:0] funcs,
  output logic                         cout
);

  logic [GW:0]   rippleC;
  logic [GW-1:0] propVec;
  logic          groupProp;

  assign rippleC[0] = cin;

  for (genvar i = 0; i < GW; i++) begin : gSlice
    aluBitSlice slice (
      .aBit  (aIn[i]),
      .bBit  (bIn[i]),
      .invB  (invB),
      .cin   (rippleC[i]),
      .prop  (propVec[i]),
      .cout  (rippleC[i+1]),
      .funcs (funcs[i])
    );
  end

  // whole group propagates: hand the incoming carry straight on
  assign groupProp = &propVec;
  assign cout      = groupProp ? cin : rippleC[GW];

endmodule

// File: rtl/aluDatapath.sv
`timescale 1ns/1ps
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrlT          ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int NG = WIDTH / GROUP;

  logic [NG:0]                      groupC;
  logic [WIDTH-1:0][NUM_FUNCS-1:0]  funcAll;

  assign groupC[0] = ctrl.carryIn;

  for (genvar g = 0; g < NG; g++) begin : gGroup
    aluSkipGroup #(.GW(GROUP)) grp (
      .aIn   (opA[g*GROUP +: GROUP]),
      .bIn   (opB[g*GROUP +: GROUP]),
      .invB  (ctrl.invertB),
      .cin   (groupC[g]),
      .funcs (funcAll[g*GROUP +: GROUP]),
      .cout  (groupC[g+1])
    );
  end

  // 8-to-1 selector per bit, AND-OR form on the one-hot pick
  for (genvar i = 0; i < WIDTH; i++) begin : gMux
    assign result[i] = |(funcAll[i] & ctrl.funcSel);
  end

  assign carryOut = groupC[NG] & ctrl.carryEn;

endmodule

// File: rtl/aluCore.sv
`timescale 1ns/1ps
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluCtrlT ctrl;

  aluControl ctl (
    .opCode (aluOpE'(opSel)),
    .ctrl   (ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH), .GROUP(GROUP)) dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/aluCoreChecker.sv
`timescale 1ns/1ps
module aluCoreChecker #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);

  logic [WIDTH:0] addRef;
  logic [WIDTH:0] subRef;

  always_comb begin
    addRef = {1'b0, opA} + {1'b0, opB};
    subRef = {1'b0, opA} + {1'b0, ~opB} + (WIDTH+1)'(1);
    if (!$isunknown({opA, opB, opSel, result, carryOut})) begin
      if (opSel == 3'b000)
        AST_ADD_SUM: assert ({carryOut, result} == addRef); // R1
      if (opSel == 3'b001)
        AST_SUB_DIFF: assert ({carryOut, result} == subRef); // R2
      if (opSel == 3'b001)
        AST_SUB_NO_BORROW: assert (carryOut == (opA >= opB)); // R2
      if (opSel == 3'b010)
        AST_NOR_BITS: assert (result == ~(opA | opB)); // R3
      if (opSel == 3'b011)
        AST_NAND_BITS: assert (result == ~(opA & opB)); // R4
      if (opSel == 3'b100)
        AST_OR_BITS: assert (result == (opA | opB)); // R5
      if (opSel == 3'b101)
        AST_AND_BITS: assert (result == (opA & opB)); // R6
      if (opSel == 3'b110)
        AST_XOR_BITS: assert (result == (opA ^ opB)); // R7
      if (opSel == 3'b111)
        AST_INV_BITS: assert (result == ~opA); // R8
      if (opSel[2] || opSel[1])
        AST_LOGIC_NO_CARRY: assert (!carryOut); // R9
    end
  end

endmodule

bind aluCore aluCoreChecker #(.WIDTH(WIDTH)) chk (
  .opA      (opA),
  .opB      (opB),
  .opSel    (opSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/aluCore_test.sv
`timescale 1ns/1ps
module aluCore_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // 16-bit instance, 4-bit groups
  logic [15:0] wA = '0, wB = '0, wRes;
  logic [2:0]  wOp = '0;
  logic        wCy;

  // narrow instance: 8 bits in 2-bit groups, swept exhaustively
  logic [7:0]  nA = '0, nB = '0, nRes;
  logic [2:0]  nOp = '0;
  logic        nCy;

  aluCore #(.WIDTH(16), .GROUP(4)) uut (
    .opA(wA), .opB(wB), .opSel(wOp), .result(wRes), .carryOut(wCy)
  );

  aluCore #(.WIDTH(8), .GROUP(2)) uutNarrow (
    .opA(nA), .opB(nB), .opSel(nOp), .result(nRes), .carryOut(nCy)
  );

  // behavioural model: returns {carry, result} for width w
  function automatic logic [16:0] refAlu(input int w, input logic [2:0] op,
                                         input logic [15:0] a, input logic [15:0] b);
    logic [31:0] m, x, y, s;
    m = (32'd1 << w) - 32'd1;
    x = {16'd0, a} & m;
    y = {16'd0, b} & m;
    case (op)
      3'd0: s = x + y;
      3'd1: s = x + ((~y) & m) + 32'd1;
      3'd2: s = (~(x | y)) & m;
      3'd3: s = (~(x & y)) & m;
      3'd4: s = x | y;
      3'd5: s = x & y;
      3'd6: s = x ^ y;
      default: s = (~x) & m;
    endcase
    refAlu = {s[w], 16'(s & m)};
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: reqOf = "R1 add";
      3'd1: reqOf = "R2 sub";
      3'd2: reqOf = "R3 nor / R9 carry";
      3'd3: reqOf = "R4 nand / R9 carry";
      3'd4: reqOf = "R5 or / R9 carry";
      3'd5: reqOf = "R6 and / R9 carry";
      3'd6: reqOf = "R7 xor / R9 carry";
      default: reqOf = "R8 invert / R9 carry";
    endcase
  endfunction

  task automatic judge(input string req, input logic [16:0] got, input logic [16:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got carry=%0b result=%h expected carry=%0b result=%h",
               req, got[16], got[15:0], exp[16], exp[15:0]);
    end
  endtask

  // drive, settle a quarter ns (never on a clock edge), compare
  task automatic runWide(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input string req);
    wOp = op; wA = a; wB = b;
    #0.25;
    judge(req, {wCy, wRes}, refAlu(16, op, a, b));
    #0.75;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  logic [15:0] corners [7];

  initial begin
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h0001; corners[4] = 16'h7FFF; corners[5] = 16'hAAAA;
    corners[6] = 16'h5555;

    repeat (2) @(posedge clk);
    rstN = 1'b1;
    #0.5;

    // initial state: zero operands, add -> zero, no carry (R1)
    judge("R1 initial zero add", {wCy, wRes}, 17'd0);
    judge("R1 initial zero add narrow", {nCy, 8'd0, nRes}, 17'd0);

    // exhaustive narrow sweep over every code and operand pair
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          nOp = 3'(op); nA = 8'(a); nB = 8'(b);
          #0.25;
          judge(reqOf(3'(op)), {nCy, 8'd0, nRes}, refAlu(8, 3'(op), 16'(a), 16'(b)));
          #0.75;
        end
      end
    end

    // wide corner pairs over all codes
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          runWide(3'(op), corners[i], corners[j], reqOf(3'(op)));

    // R2: equal operands give zero and carry 1
    runWide(3'd1, 16'h1234, 16'h1234, "R2 sub equal");
    judge("R2 sub equal literal", {wCy, wRes}, {1'b1, 16'h0000});
    runWide(3'd1, 16'h0000, 16'h0001, "R2 sub borrow");
    judge("R2 sub borrow literal", {wCy, wRes}, {1'b0, 16'hFFFF});

    // R10: carry from bit 0 travels through all four groups
    runWide(3'd0, 16'hFFFF, 16'h0001, "R10 full carry chain");
    judge("R10 full carry literal", {wCy, wRes}, {1'b1, 16'h0000});
    runWide(3'd0, 16'h0FFF, 16'h0001, "R10 carry stops in top group");
    judge("R10 partial chain literal", {wCy, wRes}, {1'b0, 16'h1000});

    // R8: opB has no effect on invert
    runWide(3'd7, 16'h00F0, 16'h0000, "R8 invert b=0");
    runWide(3'd7, 16'h00F0, 16'hFFFF, "R8 invert b=ffff");
    judge("R8 invert literal", {wCy, wRes}, {1'b0, 16'hFF0F});

    // R11: change mid-cycle, sample before the next edge
    @(posedge clk); #0.5;
    wOp = 3'd0; wA = 16'h8000; wB = 16'h8000;
    #1.0;
    judge("R11 same-cycle response", {wCy, wRes}, {1'b1, 16'h0000});
    wOp = 3'd6;
    #0.25;
    judge("R11 same-cycle op change", {wCy, wRes}, {1'b0, 16'h0000});
    #0.75;

    // random operands on every code
    for (int n = 0; n < 2000; n++)
      for (int op = 0; op < 8; op++)
        runWide(3'(op), 16'($urandom), 16'($urandom), reqOf(3'(op)));

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got hung run expected completion");
      summary();
      $finish;
    end
  end

endmodule